// File: doc/BRIEF.md
# SPI Command-Decoding Register Slave

This block is the host-facing side of a CAN controller front end. An external SPI master (mode 0) talks to it in short transactions framed by an active-low chip select. The first byte of each transaction is an opcode. The bytes after it carry addresses, masks and data for a 128-byte register map. The supported commands are:

- plain reads and writes that auto-increment the address;
- a masked bit-modify write;
- a full soft reset;
- two quick status reads;
- burst reads of the two receive buffers and a burst load of the transmit buffer;
- a request-to-send command for the transmit buffer.

The block keeps an operating-mode field, a read-only status byte that mirrors that mode, an interrupt-flag byte and an interrupt-enable byte. From these it drives an active-low interrupt line.

The CAN protocol engine is not part of this block. A small side port stands in for it. The side port can write any register, which is how the receive buffers get filled. It can also set either receive-buffer flag and acknowledge a finished transmission. All SPI pins are sampled in the system clock domain, so SCK must be slow compared with the system clock: each half period of SCK must last more than SYNC_STAGES + 3 system clocks.

Top module: `spicmd_regslave`

## Requirements
- R1: After reset every register reads 0x00, except the mode register at 0x0F, which reads 0x80. The status register at 0x0E reads 0x80, intN is high and miso is low.
- R2: Read (0x03) takes an address byte and then returns register data on every following byte. The address increments after each data byte and wraps from 0x7F to 0x00.
- R3: Write (0x02) takes an address byte and then writes every following complete byte, with the same increment and wrap. A trailing partial byte (fewer than 8 SCK rises before chip select rises) writes nothing.
- R4: Bit modify (0x05) takes an address, a mask and a data byte. Only the masked bits take the new data, and any further bytes in that transaction are ignored.
- R5: Bits 7:5 of 0x0F hold the mode: 000 normal, 010 loopback, 011 listen-only, 100 configuration. Register 0x0E reads back as those three bits over five zero bits, and writes to 0x0E have no effect.
- R6: Read status (0xA0) returns a byte with bit 0 = receive flag 0 (0x2C bit 0), bit 1 = receive flag 1 (0x2C bit 1), bit 2 = transmit request (0x30 bit 3), bit 3 = transmit-done flag (0x2C bit 2), and bits 7:4 zero.
- R7: Receive status (0xB0) returns bit 6 = receive flag 0 and bit 7 = receive flag 1, with all other bits zero.
- R8: Opcodes 0x90 and 0x94 stream registers starting at 0x61 and 0x71 respectively. When chip select rises, the flag of the buffer that was read (0x2C bit 0 or bit 1) clears, and the other flag is left as it was.
- R9: Load transmit buffer (0x40) writes the following bytes to consecutive addresses starting at 0x31.
- R10: Request-to-send (0x81) sets bit 3 of 0x30. A transmit acknowledge on the side port clears that bit and sets bit 2 of 0x2C.
- R11: The reset opcode (0xC0) returns every register to its R1 value.
- R12: intN is low exactly when some bit is set in both 0x2C and 0x2B.
- R13: Side port: sideWe writes sideData to sideAddr (a write to 0x0E is ignored). sideRxSet[0] sets bit 0 of 0x2C and sideRxSet[1] sets bit 1 of 0x2C.
- R14: Any opcode not listed above is ignored for the rest of the transaction and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock, idle low |
| csN | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from master, sampled on SCK rise |
| miso | output | 1 | SPI data to master, changes after SCK fall, low when deselected |
| intN | output | 1 | Active-low interrupt |
| sideWe | input | 1 | Side-port register write strobe |
| sideAddr | input | 7 | Side-port write address |
| sideData | input | 8 | Side-port write data |
| sideRxSet | input | 2 | Set receive-buffer flags 1 and 0 |
| sideTxAck | input | 1 | Transmission finished acknowledge |

## Verification
The bench writes and then reads back all 128 addresses in single bursts. A burst that runs past 0x7F must wrap to 0x00; a design that saturates or spills into bit 7 would return the wrong bytes. A chip-select rise in the middle of a byte must not write; a design that commits partial bytes would corrupt the next register. Bit modify is swept over shifted masks. A design that writes whole bytes, or that keeps writing on the extra trailing bytes, shows up as changed unmasked bits or a clobbered neighbour.

The receive-buffer reads are checked with both flags set. The flag must clear only at the end of the transaction and only for the buffer that was read; clearing both, or clearing early, shows up in the interrupt line and in the status bytes. Mode writes must show up in the read-only mirror, while writes aimed at the mirror must be dropped.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int REG_AW = 7;
  localparam int REG_COUNT = 1 << REG_AW;
  localparam int BYTE_W = 8;

  localparam logic [REG_AW-1:0] ADDR_STAT  = 7'h0E;
  localparam logic [REG_AW-1:0] ADDR_MODE  = 7'h0F;
  localparam logic [REG_AW-1:0] ADDR_IEN   = 7'h2B;
  localparam logic [REG_AW-1:0] ADDR_IFLG  = 7'h2C;
  localparam logic [REG_AW-1:0] ADDR_TXCTL = 7'h30;
  localparam logic [REG_AW-1:0] ADDR_TXID  = 7'h31;
  localparam logic [REG_AW-1:0] ADDR_RX0ID = 7'h61;
  localparam logic [REG_AW-1:0] ADDR_RX1ID = 7'h71;

  localparam logic [BYTE_W-1:0] MODE_RESET_VAL = 8'h80;

  localparam logic [BYTE_W-1:0] OP_RESET  = 8'hC0;
  localparam logic [BYTE_W-1:0] OP_READ   = 8'h03;
  localparam logic [BYTE_W-1:0] OP_WRITE  = 8'h02;
  localparam logic [BYTE_W-1:0] OP_BITMOD = 8'h05;
  localparam logic [BYTE_W-1:0] OP_RDSTAT = 8'hA0;
  localparam logic [BYTE_W-1:0] OP_RXSTAT = 8'hB0;
  localparam logic [BYTE_W-1:0] OP_RDRX0  = 8'h90;
  localparam logic [BYTE_W-1:0] OP_RDRX1  = 8'h94;
  localparam logic [BYTE_W-1:0] OP_LOADTX = 8'h40;
  localparam logic [BYTE_W-1:0] OP_RTS    = 8'h81;

  typedef struct packed {
    logic              wrEn;
    logic [REG_AW-1:0] wrAddr;
    logic [BYTE_W-1:0] wrData;
    logic [BYTE_W-1:0] wrMask;
    logic              setTxReq;
    logic [1:0]        clrRx;
    logic              softReset;
  } strobe_t;

  typedef enum logic [3:0] {
    ST_OPC, ST_ADDR_RD, ST_ADDR_WR, ST_ADDR_BM, ST_RD, ST_WR,
    ST_BM_MASK, ST_BM_DATA, ST_STAT, ST_RXST, ST_IGNORE
  } cmd_state_t;
endpackage

// File: rtl/spicmd_front.sv
module spicmd_front
  import spicmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              mosi,
  input  logic              txLoad,
  input  logic [BYTE_W-1:0] txByte,
  output logic              miso,
  output logic              csActive,
  output logic              csRise,
  output logic              byteValid,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sckS, csS, mosiS;
  logic sckD, csD;
  logic sckNow, csNow, mosiNow, sckRise, sckFall;
  logic [2:0] bitCnt;
  logic [BYTE_W-2:0] rxShift;
  logic [BYTE_W-1:0] txShift;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckS  <= '0;
          csS   <= '1;
          mosiS <= '0;
        end else begin
          sckS  <= {sckS[LAST-1:0], sck};
          csS   <= {csS[LAST-1:0], csN};
          mosiS <= {mosiS[LAST-1:0], mosi};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckS  <= '0;
          csS   <= '1;
          mosiS <= '0;
        end else begin
          sckS  <= sck;
          csS   <= csN;
          mosiS <= mosi;
        end
      end
    end
  endgenerate

  assign sckNow   = sckS[LAST];
  assign csNow    = csS[LAST];
  assign mosiNow  = mosiS[LAST];
  assign csActive = !csNow;
  assign csRise   = csNow && !csD;
  assign sckRise  = csActive && sckNow && !sckD;
  assign sckFall  = csActive && !sckNow && sckD;
  assign miso     = csActive && txShift[BYTE_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckD      <= 1'b0;
      csD       <= 1'b1;
      bitCnt    <= '0;
      rxShift   <= '0;
      txShift   <= '0;
      byteValid <= 1'b0;
      rxByte    <= '0;
    end else begin
      sckD      <= sckNow;
      csD       <= csNow;
      byteValid <= 1'b0;
      if (!csActive) begin
        bitCnt  <= '0;
        txShift <= '0;
      end else begin
        if (sckRise) begin
          rxShift <= {rxShift[BYTE_W-3:0], mosiNow};
          bitCnt  <= bitCnt + 3'd1;
          if (bitCnt == 3'd7) begin
            byteValid <= 1'b1;
            rxByte    <= {rxShift, mosiNow};
          end
        end
        if (sckFall && bitCnt != 3'd0) txShift <= {txShift[BYTE_W-2:0], 1'b0};
        if (txLoad) txShift <= txByte;
      end
    end
  end
endmodule

// File: rtl/spicmd_ctrl.sv
module spicmd_ctrl
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActive,
  input  logic              csRise,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic [BYTE_W-1:0] rdData,
  input  logic [BYTE_W-1:0] statusByte,
  input  logic [BYTE_W-1:0] rxStatByte,
  output strobe_t           strb,
  output logic [REG_AW-1:0] rdAddr,
  output logic              txLoad,
  output logic [BYTE_W-1:0] txByte
);
  cmd_state_t state;
  logic [REG_AW-1:0] addr;
  logic [BYTE_W-1:0] maskReg;
  logic [1:0] pendRx;
  logic loadNext;

  assign rdAddr = addr;
  assign txLoad = loadNext;

  always_comb begin
    case (state)
      ST_RD:   txByte = rdData;
      ST_STAT: txByte = statusByte;
      ST_RXST: txByte = rxStatByte;
      default: txByte = '0;
    endcase
  end

  always_comb begin
    strb = '0;
    strb.wrMask = '1;
    strb.wrAddr = addr;
    strb.wrData = rxByte;
    if (byteValid) begin
      case (state)
        ST_WR: strb.wrEn = 1'b1;
        ST_BM_DATA: begin
          strb.wrEn   = 1'b1;
          strb.wrMask = maskReg;
        end
        ST_OPC: begin
          strb.softReset = (rxByte == OP_RESET);
          strb.setTxReq  = (rxByte == OP_RTS);
        end
        default: ;
      endcase
    end
    if (csRise) strb.clrRx = pendRx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_OPC;
      addr     <= '0;
      maskReg  <= '0;
      pendRx   <= '0;
      loadNext <= 1'b0;
    end else begin
      loadNext <= byteValid;
      if (!csActive) begin
        state  <= ST_OPC;
        pendRx <= '0;
      end else if (byteValid) begin
        case (state)
          ST_OPC: begin
            case (rxByte)
              OP_READ:   state <= ST_ADDR_RD;
              OP_WRITE:  state <= ST_ADDR_WR;
              OP_BITMOD: state <= ST_ADDR_BM;
              OP_RDSTAT: state <= ST_STAT;
              OP_RXSTAT: state <= ST_RXST;
              OP_RDRX0: begin
                state     <= ST_RD;
                addr      <= ADDR_RX0ID;
                pendRx[0] <= 1'b1;
              end
              OP_RDRX1: begin
                state     <= ST_RD;
                addr      <= ADDR_RX1ID;
                pendRx[1] <= 1'b1;
              end
              OP_LOADTX: begin
                state <= ST_WR;
                addr  <= ADDR_TXID;
              end
              default: state <= ST_IGNORE;
            endcase
          end
          ST_ADDR_RD: begin
            addr  <= rxByte[REG_AW-1:0];
            state <= ST_RD;
          end
          ST_ADDR_WR: begin
            addr  <= rxByte[REG_AW-1:0];
            state <= ST_WR;
          end
          ST_ADDR_BM: begin
            addr  <= rxByte[REG_AW-1:0];
            state <= ST_BM_MASK;
          end
          ST_RD, ST_WR: addr <= addr + 7'd1;
          ST_BM_MASK: begin
            maskReg <= rxByte;
            state   <= ST_BM_DATA;
          end
          ST_BM_DATA: state <= ST_IGNORE;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spicmd_regs.sv
module spicmd_regs
  import spicmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [REG_AW-1:0] rdAddr,
  input  logic              sideWe,
  input  logic [REG_AW-1:0] sideAddr,
  input  logic [BYTE_W-1:0] sideData,
  input  logic [1:0]        sideRxSet,
  input  logic              sideTxAck,
  output logic [BYTE_W-1:0] rdData,
  output logic [BYTE_W-1:0] statusByte,
  output logic [BYTE_W-1:0] rxStatByte,
  output logic [BYTE_W-1:0] flagReg,
  output logic [BYTE_W-1:0] enReg,
  output logic [BYTE_W-1:0] txCtrl,
  output logic [2:0]        modeBits,
  output logic              intN
);
  logic [REG_COUNT-1:0][BYTE_W-1:0] regs, regNext;

  always_comb begin
    regNext = regs;
    if (strb.wrEn && strb.wrAddr != ADDR_STAT)
      regNext[strb.wrAddr] = (regs[strb.wrAddr] & ~strb.wrMask) | (strb.wrData & strb.wrMask);
    if (sideWe && sideAddr != ADDR_STAT)
      regNext[sideAddr] = sideData;
    regNext[ADDR_IFLG][1:0] = (regNext[ADDR_IFLG][1:0] & ~strb.clrRx) | sideRxSet;
    if (strb.setTxReq) regNext[ADDR_TXCTL][3] = 1'b1;
    if (sideTxAck) begin
      regNext[ADDR_TXCTL][3] = 1'b0;
      regNext[ADDR_IFLG][2]  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regs <= '0;
      regs[ADDR_MODE] <= MODE_RESET_VAL;
    end else if (strb.softReset) begin
      regs <= '0;
      regs[ADDR_MODE] <= MODE_RESET_VAL;
    end else begin
      regs <= regNext;
    end
  end

  assign modeBits   = regs[ADDR_MODE][7:5];
  assign flagReg    = regs[ADDR_IFLG];
  assign enReg      = regs[ADDR_IEN];
  assign txCtrl     = regs[ADDR_TXCTL];
  assign rdData     = (rdAddr == ADDR_STAT) ? {modeBits, 5'b0} : regs[rdAddr];
  assign statusByte = {4'b0, flagReg[2], txCtrl[3], flagReg[1], flagReg[0]};
  assign rxStatByte = {flagReg[1], flagReg[0], 6'b0};
  assign intN       = !(|(flagReg & enReg));
endmodule

// File: rtl/spicmd_regslave.sv
module spicmd_regslave
  import spicmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sck,
  input  logic       csN,
  input  logic       mosi,
  output logic       miso,
  output logic       intN,
  input  logic       sideWe,
  input  logic [6:0] sideAddr,
  input  logic [7:0] sideData,
  input  logic [1:0] sideRxSet,
  input  logic       sideTxAck
);
  strobe_t strb;
  logic csActive, csRise, byteValid, txLoad;
  logic [BYTE_W-1:0] rxByte, txByte, rdData, statusByte, rxStatByte;
  logic [BYTE_W-1:0] flagReg, enReg, txCtrl;
  logic [REG_AW-1:0] rdAddr;
  logic [2:0] modeBits;

  spicmd_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .mosi(mosi),
    .txLoad(txLoad), .txByte(txByte), .miso(miso), .csActive(csActive),
    .csRise(csRise), .byteValid(byteValid), .rxByte(rxByte)
  );

  spicmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .csRise(csRise),
    .byteValid(byteValid), .rxByte(rxByte), .rdData(rdData),
    .statusByte(statusByte), .rxStatByte(rxStatByte), .strb(strb),
    .rdAddr(rdAddr), .txLoad(txLoad), .txByte(txByte)
  );

  spicmd_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr),
    .sideWe(sideWe), .sideAddr(sideAddr), .sideData(sideData),
    .sideRxSet(sideRxSet), .sideTxAck(sideTxAck), .rdData(rdData),
    .statusByte(statusByte), .rxStatByte(rxStatByte), .flagReg(flagReg),
    .enReg(enReg), .txCtrl(txCtrl), .modeBits(modeBits), .intN(intN)
  );
endmodule

// File: rtl/spicmd_regslave_chk.sv
module spicmd_regslave_chk
  import spicmd_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input strobe_t    strb,
  input logic       sideWe,
  input logic [6:0] sideAddr,
  input logic [1:0] sideRxSet,
  input logic       sideTxAck,
  input logic [7:0] flagReg,
  input logic [7:0] enReg,
  input logic [7:0] txCtrl,
  input logic [2:0] modeBits,
  input logic       intN
);
  AST_RX0_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    (sideRxSet[0] && !strb.softReset) |=> flagReg[0]); // R13

  AST_RX0_FLAG_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrRx[0] && !sideRxSet[0] && !(sideWe && sideAddr == ADDR_IFLG)) |=> !flagReg[0]); // R8

  AST_TX_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (sideTxAck && !strb.softReset) |=> (!txCtrl[3] && flagReg[2])); // R10

  AST_RTS_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setTxReq && !sideTxAck) |=> txCtrl[3]); // R10

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strb.softReset |=> (modeBits == 3'b100 && flagReg == 8'h00)); // R11

  AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sideRxSet[0] && enReg[0] && !sideWe && !strb.wrEn && !strb.softReset) |=> !intN); // R12
endmodule

bind spicmd_regslave spicmd_regslave_chk u_chk (.*);

// File: tb/sim_spicmd_regslave.sv
module sim_spicmd_regslave;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso, intN;
  logic sideWe = 1'b0, sideTxAck = 1'b0;
  logic [6:0] sideAddr = '0;
  logic [7:0] sideData = '0;
  logic [1:0] sideRxSet = '0;

  int nChecks = 0, nFail = 0, cyc = 0;
  logic [7:0] tbuf [0:139];
  logic [7:0] rbuf [0:139];
  logic [7:0] m [0:127];
  logic [7:0] v;

  always #5 clk = ~clk;

  spicmd_regslave u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(int n, int partial = 0);
    csN = 1'b0;
    waitClk(6);
    for (int i = 0; i < n; i++)
      for (int b = 7; b >= 0; b--) begin
        mosi = tbuf[i][b];
        waitClk(8);
        rbuf[i][b] = miso;
        sck = 1'b1;
        waitClk(8);
        sck = 1'b0;
      end
    for (int b = 7; b > 7 - partial; b--) begin
      mosi = tbuf[n][b];
      waitClk(8);
      sck = 1'b1;
      waitClk(8);
      sck = 1'b0;
    end
    waitClk(6);
    csN = 1'b1;
    waitClk(12);
  endtask

  function automatic logic [7:0] mRead(int a);
    return (a == 8'h0E) ? {m[8'h0F][7:5], 5'b0} : m[a];
  endfunction

  function automatic void mWrite(int a, logic [7:0] mask, logic [7:0] d);
    if (a != 8'h0E) m[a] = (m[a] & ~mask) | (d & mask);
  endfunction

  function automatic void mReset();
    for (int i = 0; i < 128; i++) m[i] = 8'h00;
    m[8'h0F] = 8'h80;
  endfunction

  task automatic regRead(int a, output logic [7:0] d);
    tbuf[0] = 8'h03; tbuf[1] = 8'(a); tbuf[2] = 8'h00;
    xfer(3);
    d = rbuf[2];
  endtask

  task automatic regWrite(int a, logic [7:0] d);
    tbuf[0] = 8'h02; tbuf[1] = 8'(a); tbuf[2] = d;
    xfer(3);
    mWrite(a, 8'hFF, d);
  endtask

  task automatic sideWrite(int a, logic [7:0] d);
    @(negedge clk);
    sideWe = 1'b1; sideAddr = 7'(a); sideData = d;
    @(negedge clk);
    sideWe = 1'b0;
    mWrite(a, 8'hFF, d);
  endtask

  task automatic cmd1(logic [7:0] op, output logic [7:0] d);
    tbuf[0] = op; tbuf[1] = 8'h00;
    xfer(2);
    d = rbuf[1];
  endtask

  initial begin
    mReset();
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    // R1 reset state
    check("R1 intN", {7'b0, intN}, 8'h01);
    check("R1 miso", {7'b0, miso}, 8'h00);
    regRead(8'h0E, v); check("R1 status", v, 8'h80);
    regRead(8'h0F, v); check("R1 mode", v, 8'h80);
    regRead(8'h2C, v); check("R1 flags", v, 8'h00);

    // R3 burst write across the whole map, R2 burst read back
    tbuf[0] = 8'h02; tbuf[1] = 8'h00;
    for (int i = 0; i < 128; i++) begin
      tbuf[i+2] = 8'((i * 37 + 11) & 8'hFF);
      mWrite(i, 8'hFF, tbuf[i+2]);
    end
    xfer(130);
    tbuf[0] = 8'h03; tbuf[1] = 8'h00;
    for (int i = 0; i < 128; i++) tbuf[i+2] = 8'h00;
    xfer(130);
    for (int i = 0; i < 128; i++) check("R2 R3 sweep", rbuf[i+2], mRead(i));
    check("R12 intN after sweep", {7'b0, intN}, {7'b0, ~|(m[8'h2C] & m[8'h2B])});

    // R3 wrap 0x7F -> 0x00, R2 read wrap
    tbuf[0] = 8'h02; tbuf[1] = 8'h7E; tbuf[2] = 8'h11; tbuf[3] = 8'h22; tbuf[4] = 8'h33;
    xfer(5);
    mWrite(8'h7E, 8'hFF, 8'h11); mWrite(8'h7F, 8'hFF, 8'h22); mWrite(0, 8'hFF, 8'h33);
    tbuf[0] = 8'h03; tbuf[1] = 8'h7F; tbuf[2] = 0; tbuf[3] = 0;
    xfer(4);
    check("R2 wrap 7F", rbuf[2], 8'h22);
    check("R2 R3 wrap 00", rbuf[3], 8'h33);

    // R3 partial trailing byte writes nothing
    tbuf[0] = 8'h02; tbuf[1] = 8'h50; tbuf[2] = 8'hAB; tbuf[3] = 8'hFF;
    xfer(3, 4);
    mWrite(8'h50, 8'hFF, 8'hAB);
    regRead(8'h50, v); check("R3 full byte", v, 8'hAB);
    regRead(8'h51, v); check("R3 partial ignored", v, m[8'h51]);

    // R4 bit modify sweep, extra byte ignored
    regWrite(8'h45, 8'hA5);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] mk, dt;
      mk = 8'(8'h0F << (k % 5)) ^ 8'(k);
      dt = 8'(~(k * 29));
      tbuf[0] = 8'h05; tbuf[1] = 8'h45; tbuf[2] = mk; tbuf[3] = dt; tbuf[4] = 8'h5A;
      xfer(5);
      mWrite(8'h45, mk, dt);
      regRead(8'h45, v); check("R4 masked", v, m[8'h45]);
    end
    regRead(8'h46, v); check("R4 neighbour", v, m[8'h46]);

    // R5 mode mirror
    for (int k = 0; k < 4; k++) begin
      logic [2:0] md;
      md = (k == 0) ? 3'b000 : (k == 1) ? 3'b010 : (k == 2) ? 3'b011 : 3'b100;
      regWrite(8'h0F, {md, 5'b00101});
      regRead(8'h0E, v); check("R5 mirror", v, {md, 5'b0});
      regRead(8'h0F, v); check("R5 mode reg", v, {md, 5'b00101});
    end
    regWrite(8'h0E, 8'hFF);
    regRead(8'h0E, v); check("R5 status write ignored", v, 8'h80);

    // clear flags, enables, tx control
    regWrite(8'h2C, 8'h00); regWrite(8'h2B, 8'h00); regWrite(8'h30, 8'h00);
    check("R12 intN idle", {7'b0, intN}, 8'h01);

    // R13 side fill of both receive buffers
    for (int j = 0; j < 13; j++) sideWrite(8'h61 + j, 8'(8'hC1 + j * 7));
    for (int j = 0; j < 13; j++) sideWrite(8'h71 + j, 8'(8'h19 + j * 13));
    @(negedge clk); sideRxSet = 2'b01; @(negedge clk); sideRxSet = 2'b00;
    regWrite(8'h2B, 8'h07);
    check("R12 R13 intN rx0", {7'b0, intN}, 8'h00);
    cmd1(8'hA0, v); check("R6 rx0", v, 8'h01);
    cmd1(8'hB0, v); check("R7 rx0", v, 8'h40);
    @(negedge clk); sideRxSet = 2'b10; @(negedge clk); sideRxSet = 2'b00;
    cmd1(8'hA0, v); check("R6 both", v, 8'h03);
    cmd1(8'hB0, v); check("R7 both", v, 8'hC0);

    // R8 buffer reads
    tbuf[0] = 8'h90;
    for (int j = 1; j <= 13; j++) tbuf[j] = 8'h00;
    xfer(14);
    for (int j = 0; j < 13; j++) check("R8 rx0 data", rbuf[j+1], m[8'h61 + j]);
    regRead(8'h2C, v); check("R8 rx0 flag cleared", v, 8'h02);
    check("R12 intN rx1 pending", {7'b0, intN}, 8'h00);
    tbuf[0] = 8'h94;
    xfer(14);
    for (int j = 0; j < 13; j++) check("R8 rx1 data", rbuf[j+1], m[8'h71 + j]);
    regRead(8'h2C, v); check("R8 rx1 flag cleared", v, 8'h00);
    check("R12 intN released", {7'b0, intN}, 8'h01);

    // R9 load transmit buffer
    tbuf[0] = 8'h40;
    for (int j = 0; j < 13; j++) begin
      tbuf[j+1] = 8'(8'h3C ^ (j * 17));
      mWrite(8'h31 + j, 8'hFF, tbuf[j+1]);
    end
    xfer(14);
    tbuf[0] = 8'h03; tbuf[1] = 8'h31;
    for (int j = 2; j < 15; j++) tbuf[j] = 8'h00;
    xfer(15);
    for (int j = 0; j < 13; j++) check("R9 tx load", rbuf[j+2], m[8'h31 + j]);

    // R10 request to send and acknowledge
    tbuf[0] = 8'h81; xfer(1);
    regRead(8'h30, v); check("R10 txreq set", v, 8'h08);
    cmd1(8'hA0, v); check("R6 txreq", v, 8'h04);
    @(negedge clk); sideTxAck = 1'b1; @(negedge clk); sideTxAck = 1'b0;
    regRead(8'h30, v); check("R10 txreq cleared", v, 8'h00);
    regRead(8'h2C, v); check("R10 tx flag", v, 8'h04);
    cmd1(8'hA0, v); check("R6 txdone", v, 8'h08);
    check("R12 intN tx", {7'b0, intN}, 8'h00);

    // R14 unknown opcode
    tbuf[0] = 8'h7A; tbuf[1] = 8'h2C; tbuf[2] = 8'h00; tbuf[3] = 8'h00;
    xfer(4);
    regRead(8'h2C, v); check("R14 unknown ignored", v, 8'h04);

    // R11 reset opcode
    tbuf[0] = 8'hC0; xfer(1);
    mReset();
    regRead(8'h0F, v); check("R11 mode", v, 8'h80);
    regRead(8'h0E, v); check("R11 status", v, 8'h80);
    regRead(8'h2C, v); check("R11 flags", v, 8'h00);
    regRead(8'h31, v); check("R11 tx buffer", v, 8'h00);
    check("R11 intN", {7'b0, intN}, 8'h01);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule